// File: doc/BRIEF.md
# Wide Vector Register File with Bulk Zeroing

This block holds the architectural vector registers of a SIMD datapath. It has sixteen entries of 256 bits, two combinational read ports and one write port. An operation with three operands reads two sources and names a separate destination, so neither source is overwritten.

A write carries a width select. A full write replaces the whole entry. A half write changes only the low 128 bits, because the narrow register view is the low half of the wide entry. Two single-cycle commands act on every entry at once. One clears the upper halves of all entries. The other clears all entries and marks every entry as unused.

Each entry has a usage tag. Any write sets it, the clear-all command and reset clear it, and all sixteen tags are output as one vector.

Reset is asynchronous and active low. The enclosing design releases it in step with the clock.

Top module: `vec_regfile`

## Requirements
- R1: While `rst_n` is low, every entry reads as zero and `used_o` is all zeros.
- R2: A write with `wr_en`=1 and `wr_wide`=1 replaces all 256 bits of entry `wr_addr` with `wr_data`. The new value is readable after the next rising clock edge.
- R3: A write with `wr_en`=1 and `wr_wide`=0 loads `wr_data[127:0]` into bits 127:0 of the entry. Bits 255:128 of the entry keep their value.
- R4: The two read ports are combinational and independent. `rd_a_data` shows entry `rd_a_addr` and `rd_b_data` shows entry `rd_b_addr`, for any pair of addresses including equal ones.
- R5: There is no write-through path. In the cycle of a write, a read of the entry being written returns the old contents.
- R6: A cycle with `clr_upper`=1 sets bits 255:128 of all 16 entries to zero. The low halves and `used_o` are unchanged.
- R7: A cycle with `clr_all`=1 sets all bits of every entry to zero and sets `used_o` to zero.
- R8: Any write, full or half, sets bit `wr_addr` of `used_o`. Bit i of `used_o` belongs to entry i.
- R9: When a write and a clear command occur in the same cycle, the clear is applied first and the write is applied on top of it. A half write combined with either clear therefore leaves the upper half at zero.
- R10: When `clr_upper` and `clr_all` are both high in one cycle, the result is the same as `clr_all` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_addr | input | 4 | Address for source A |
| rd_a_data | output | 256 | Contents of entry `rd_a_addr` |
| rd_b_addr | input | 4 | Address for source B |
| rd_b_data | output | 256 | Contents of entry `rd_b_addr` |
| wr_en | input | 1 | Write strobe |
| wr_wide | input | 1 | 1 = write all 256 bits, 0 = write the low 128 bits only |
| wr_addr | input | 4 | Destination entry |
| wr_data | input | 256 | Write data |
| clr_upper | input | 1 | Clear bits 255:128 of every entry |
| clr_all | input | 1 | Clear every entry and every usage tag |
| used_o | output | 16 | Usage tag of each entry |

## Verification
- Reads have no latency. A change of read address is checked after a short settling delay in the same cycle, without waiting for a clock edge.
- Writes and both clear commands update state on the rising edge that follows the stimulus. The bench drives each command at the falling edge, waits for one rising edge, and then compares every entry and the tag vector with its reference array.
- The no-bypass rule is checked before that edge, while the write is still being driven. At that point the read of the written entry must still return the old value.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  localparam int unsigned VRF_ENTRIES = 16;
  localparam int unsigned VRF_WIDTH   = 256;

  typedef enum logic {
    WR_HALF = 1'b0,
    WR_FULL = 1'b1
  } wr_size_e;
endpackage

// File: rtl/vrf_entry.sv
module vrf_entry
  import vrf_pkg::*;
#(
  parameter int unsigned DATA_W = VRF_WIDTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_upper_i,
  input  logic              clr_all_i,
  output logic [DATA_W-1:0] q_o,
  output logic              used_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] q_r, q_nxt;
  logic              used_r, used_nxt;
  logic              en;

  // clear first, then write on top
  always_comb begin
    q_nxt    = q_r;
    used_nxt = used_r;
    if (clr_all_i) begin
      q_nxt    = '0;
      used_nxt = 1'b0;
    end else if (clr_upper_i) begin
      q_nxt[DATA_W-1:HALF_W] = '0;
    end
    if (we_i) begin
      q_nxt[HALF_W-1:0] = wdata_i[HALF_W-1:0];
      if (wr_size_e'(wide_i) == WR_FULL) begin
        q_nxt[DATA_W-1:HALF_W] = wdata_i[DATA_W-1:HALF_W];
      end
      used_nxt = 1'b1;
    end
  end

  assign en = we_i | clr_upper_i | clr_all_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r    <= '0;
      used_r <= 1'b0;
    end else if (en) begin
      q_r    <= q_nxt;
      used_r <= used_nxt;
    end
  end

  assign q_o    = q_r;
  assign used_o = used_r;

  p_full_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && wide_i) |=> (q_r == $past(wdata_i)));

  p_half_keeps_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !wide_i && !clr_upper_i && !clr_all_i) |=>
      (q_r[DATA_W-1:HALF_W] == $past(q_r[DATA_W-1:HALF_W])));

  p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && !clr_upper_i && !clr_all_i) |=> ($stable(q_r) && $stable(used_r)));

  p_upper_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_upper_i && !clr_all_i && !we_i) |=>
      (q_r[DATA_W-1:HALF_W] == '0 && q_r[HALF_W-1:0] == $past(q_r[HALF_W-1:0])
       && used_r == $past(used_r)));

  p_all_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all_i && !we_i) |=> (q_r == '0 && !used_r));

  p_tag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> used_r);

  p_half_after_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !wide_i && (clr_upper_i || clr_all_i)) |=>
      (q_r[DATA_W-1:HALF_W] == '0 && q_r[HALF_W-1:0] == $past(wdata_i[HALF_W-1:0])));
endmodule

// File: rtl/vrf_read_port.sv
module vrf_read_port
  import vrf_pkg::*;
#(
  parameter int unsigned ENTRIES = VRF_ENTRIES,
  parameter int unsigned DATA_W  = VRF_WIDTH,
  localparam int unsigned ADDR_W = $clog2(ENTRIES)
) (
  input  logic [DATA_W-1:0] regs_i [ENTRIES],
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (addr_i == ADDR_W'(i)) data_o = regs_i[i];
    end
  end
endmodule

// File: rtl/vec_regfile.sv
module vec_regfile
  import vrf_pkg::*;
#(
  parameter int unsigned ENTRIES = VRF_ENTRIES,
  parameter int unsigned DATA_W  = VRF_WIDTH,
  localparam int unsigned ADDR_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  rd_a_addr,
  output logic [DATA_W-1:0]  rd_a_data,
  input  logic [ADDR_W-1:0]  rd_b_addr,
  output logic [DATA_W-1:0]  rd_b_data,
  input  logic               wr_en,
  input  logic               wr_wide,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               clr_upper,
  input  logic               clr_all,
  output logic [ENTRIES-1:0] used_o
);
  logic [DATA_W-1:0]  regs [ENTRIES];
  logic [ENTRIES-1:0] entry_we;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign entry_we[g] = wr_en && (wr_addr == ADDR_W'(g));

    vrf_entry #(.DATA_W(DATA_W)) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_i       (entry_we[g]),
      .wide_i     (wr_wide),
      .wdata_i    (wr_data),
      .clr_upper_i(clr_upper),
      .clr_all_i  (clr_all),
      .q_o        (regs[g]),
      .used_o     (used_o[g])
    );
  end

  vrf_read_port #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_rd_a (
    .regs_i(regs), .addr_i(rd_a_addr), .data_o(rd_a_data)
  );

  vrf_read_port #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_rd_b (
    .regs_i(regs), .addr_i(rd_b_addr), .data_o(rd_b_data)
  );

  p_single_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(entry_we));

  p_tags_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !wr_en) |=> (used_o == '0));

  p_both_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && clr_upper && !wr_en) |=> (used_o == '0 && rd_a_data == '0 && rd_b_data == '0));

  p_tag_only_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_all) |=> ($countones(used_o) >= 1 && used_o[$past(wr_addr)]));
endmodule

// File: tb/test_vec_regfile.sv
module test_vec_regfile;
  localparam int N  = 16;
  localparam int W  = 256;
  localparam int HW = W / 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   rd_a_addr, rd_b_addr, wr_addr;
  logic [W-1:0] rd_a_data, rd_b_data, wr_data;
  logic         wr_en, wr_wide, clr_upper, clr_all;
  logic [N-1:0] used_o;

  logic [W-1:0] m   [N];
  logic [N-1:0] mt;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vec_regfile i_vec_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_wide(wr_wide), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr_upper(clr_upper), .clr_all(clr_all), .used_o(used_o)
  );

  function automatic logic [W-1:0] pat(int k);
    logic [W-1:0] v;
    for (int j = 0; j < W / 32; j++)
      v[j*32 +: 32] = 32'h9E3779B9 * (k + 1) ^ (32'(j) << 24) ^ 32'(k * 131 + j);
    return v;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_file(string req);
    for (int i = 0; i < N; i++) begin
      rd_a_addr = 4'(i);
      rd_b_addr = 4'(N - 1 - i);
      #1;
      chk(req, rd_a_data, m[i]);
      chk(req, rd_b_data, m[N - 1 - i]);
    end
    chk(req, W'(used_o), W'(mt));
  endtask

  // drive one cycle at negedge, update model per requirements, settle past posedge
  task automatic cycle(bit we, bit wide, int addr, logic [W-1:0] d, bit cu, bit ca);
    @(negedge clk);
    wr_en = we; wr_wide = wide; wr_addr = 4'(addr); wr_data = d;
    clr_upper = cu; clr_all = ca;
    @(posedge clk);
    #1;
    wr_en = 1'b0; clr_upper = 1'b0; clr_all = 1'b0;
    if (ca) begin
      for (int i = 0; i < N; i++) m[i] = '0;
      mt = '0;
    end else if (cu) begin
      for (int i = 0; i < N; i++) m[i][W-1:HW] = '0;
    end
    if (we) begin
      m[addr][HW-1:0] = d[HW-1:0];
      if (wide) m[addr][W-1:HW] = d[W-1:HW];
      mt[addr] = 1'b1;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0; wr_wide = 1'b0; wr_addr = '0; wr_data = '0;
    clr_upper = 1'b0; clr_all = 1'b0; rd_a_addr = '0; rd_b_addr = '0;
    for (int i = 0; i < N; i++) m[i] = '0;
    mt = '0;
    repeat (3) @(posedge clk);
    check_file("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R2 / R8: full writes, tag checked after each
    for (int i = 0; i < N; i++) begin
      cycle(1, 1, i, pat(i), 0, 0);
      chk("R8 tag", W'(used_o), W'(mt));
    end
    check_file("R2 full write");

    // R3: half writes to even entries
    for (int i = 0; i < N; i += 2) cycle(1, 0, i, pat(100 + i), 0, 0);
    check_file("R3 half write");

    // R5: no bypass
    @(negedge clk);
    wr_en = 1'b1; wr_wide = 1'b1; wr_addr = 4'd5; wr_data = pat(55);
    rd_a_addr = 4'd5; rd_b_addr = 4'd5;
    #1;
    chk("R5 old value A", rd_a_data, m[5]);
    chk("R5 old value B", rd_b_data, m[5]);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    m[5] = pat(55);
    chk("R5 new value", rd_a_data, m[5]);

    // R6
    cycle(0, 0, 0, '0, 1, 0);
    check_file("R6 clear upper");

    // R7
    for (int i = 0; i < N; i++) cycle(1, 1, i, pat(200 + i), 0, 0);
    cycle(0, 0, 0, '0, 0, 1);
    check_file("R7 clear all");

    // R8: half writes set tags
    cycle(1, 0, 3, pat(300), 0, 0);
    cycle(1, 0, 9, pat(301), 0, 0);
    cycle(1, 0, 15, pat(302), 0, 0);
    check_file("R8 half-write tags");

    // R9: clear and write in same cycle
    for (int i = 0; i < N; i++) cycle(1, 1, i, pat(400 + i), 0, 0);
    cycle(1, 0, 2, pat(410), 1, 0);
    check_file("R9 half write with clear upper");
    cycle(1, 0, 4, pat(411), 0, 1);
    check_file("R9 half write with clear all");
    cycle(1, 1, 7, pat(412), 0, 1);
    check_file("R9 full write with clear all");
    cycle(1, 1, 8, pat(413), 1, 0);
    check_file("R9 full write with clear upper");

    // R10
    for (int i = 0; i < N; i++) cycle(1, i % 2, i, pat(500 + i), 0, 0);
    cycle(0, 0, 0, '0, 1, 1);
    check_file("R10 both clears");

    // R4: exhaustive address pairs
    for (int i = 0; i < N; i++) cycle(1, 1, i, pat(600 + i), 0, 0);
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        rd_a_addr = 4'(a);
        rd_b_addr = 4'(b);
        #1;
        chk("R4 port A", rd_a_data, m[a]);
        chk("R4 port B", rd_b_data, m[b]);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule